// File: doc/BRIEF.md
# Per-Bank Precharge Timing Guard

This block sits beside a DDR2 command scheduler for an eight-bank device. It watches the stream of issued commands and keeps two timers for each bank.

The first timer counts down the read-to-precharge or write-to-precharge gap. While it runs, a precharge to that bank is not yet legal. The second timer counts down the precharge period. When it ends, the bank is idle and may be activated again. From the timers the block gives, for every bank, a "precharge allowed" flag and an "idle" flag. It also gives one flag for precharging all banks at once. The scheduler reads these flags before it chooses its next command.

The gaps are worked out from configuration inputs: additive latency, write latency, burst length, the read-to-precharge time in nanoseconds, the clock period in nanoseconds, write recovery in cycles and precharge time in cycles. A one-cycle pulse flags a precharge that was issued too early. The early command still takes effect on the timers.

Top module: `prech_guard`

## Requirements
- R1: After reset, every bit of `pre_ok` and `idle` is 1, `pre_all_ok` is 1 and `viol` is 0.
- R2: A read (op 1) or read with auto-precharge (op 2) on edge E makes `pre_ok` of that bank 0 until edge E+G-1, and 1 after it. Here G = AL + BL/2 + max(RTP,2) - 2 and RTP = ceil(`cfg_trtp_ns` / `cfg_tck_ns`).
- R3: When RTP is below 2, the value 2 is used in its place in the read gap.
- R4: A write (op 3) or write with auto-precharge (op 4) on edge E makes `pre_ok` of that bank 0 until edge E+G-1, with G = WL + BL/2 + `cfg_twr`.
- R5: BL is 8 when `cfg_bl8` is 1 and 4 when it is 0.
- R6: A later read or write never makes a bank's pending gap shorter; the longer of the remaining and the new gap applies. When a timer reaches zero it stays there, and the flag stays 1.
- R7: A single-bank precharge (op 5) on edge E makes `idle` of that bank 0 until edge E+`cfg_trp`-1, and 1 after it.
- R8: A precharge all (op 6) on edge E makes every `idle` bit 0 until edge E+`cfg_trp`, and 1 after it. `pre_all_ok` is 1 only when every `pre_ok` bit is 1.
- R9: Each bank's precharge period restarts at the latest precharge that covered it, whether single-bank or all-bank.
- R10: `viol` is 1 for one cycle after an edge that took a precharge to a bank whose `pre_ok` was 0, or a precharge all while `pre_all_ok` was 0. The command still restarts the precharge period.
- R11: A read or write makes `idle` of its bank 0 until a precharge covers that bank. Banks that the command does not address keep their flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is issued on this edge |
| cmd_op | input | 3 | 1 rd, 2 rd+ap, 3 wr, 4 wr+ap, 5 precharge bank, 6 precharge all |
| cmd_bank | input | BW | Addressed bank |
| cfg_al | input | LW | Additive latency, cycles |
| cfg_wl | input | LW | Write latency, cycles |
| cfg_bl8 | input | 1 | 1: burst 8, 0: burst 4 |
| cfg_trtp_ns | input | NW | Read-to-precharge time, ns |
| cfg_tck_ns | input | NW | Clock period, ns |
| cfg_twr | input | TW | Write recovery, cycles |
| cfg_trp | input | TW | Precharge time, cycles |
| pre_ok | output | NB | Per bank: a precharge is legal now |
| idle | output | NB | Per bank: precharge period over, bank idle |
| pre_all_ok | output | 1 | A precharge all is legal now |
| viol | output | 1 | Early precharge seen on the previous edge |

## Verification
The assertions assume `cfg_tck_ns` and `cfg_trp` are at least 1. They also assume the configuration stays fixed while any timer is running. The bench meets this by changing the configuration only when every bank is idle and ready, and by keeping both values non-zero. A read or write always gives a gap of at least two cycles, so the properties may rely on `pre_ok` dropping on the cycle after such a command.

// File: rtl/prech_guard.sv
module prech_guard #(
  parameter int NB = 8,
  parameter int BW = $clog2(NB),
  parameter int LW = 4,
  parameter int NW = 6,
  parameter int TW = 5,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_op,
  input  logic [BW-1:0] cmd_bank,
  input  logic [LW-1:0] cfg_al,
  input  logic [LW-1:0] cfg_wl,
  input  logic          cfg_bl8,
  input  logic [NW-1:0] cfg_trtp_ns,
  input  logic [NW-1:0] cfg_tck_ns,
  input  logic [TW-1:0] cfg_twr,
  input  logic [TW-1:0] cfg_trp,
  output logic [NB-1:0] pre_ok,
  output logic [NB-1:0] idle,
  output logic          pre_all_ok,
  output logic          viol
);
  localparam int N1 = NW + 1;
  localparam logic [2:0] OP_RD = 3'd1, OP_RDA = 3'd2, OP_WR = 3'd3,
                         OP_WRA = 3'd4, OP_PRE = 3'd5, OP_PRA = 3'd6;

  logic [CW-1:0] pc [NB];
  logic [CW-1:0] rc [NB];
  logic [NB-1:0] opn;
  logic          viol_q;

  wire is_rd  = cmd_valid && (cmd_op == OP_RD || cmd_op == OP_RDA);
  wire is_wr  = cmd_valid && (cmd_op == OP_WR || cmd_op == OP_WRA);
  wire is_pre = cmd_valid && (cmd_op == OP_PRE);
  wire is_pra = cmd_valid && (cmd_op == OP_PRA);

  wire [N1-1:0] rtp_c = ({1'b0, cfg_trtp_ns} + {1'b0, cfg_tck_ns} - N1'(1)) / {1'b0, cfg_tck_ns};
  wire [N1-1:0] rtp_m = (rtp_c < N1'(2)) ? N1'(2) : rtp_c;
  wire [CW-1:0] half  = cfg_bl8 ? CW'(4) : CW'(2);
  wire [CW-1:0] g_rd  = CW'(cfg_al) + half + CW'(rtp_m) - CW'(2);
  wire [CW-1:0] g_wr  = CW'(cfg_wl) + half + CW'(cfg_twr);
  wire [CW-1:0] g_ld  = (is_rd ? g_rd : g_wr) - CW'(1);

  genvar gi;
  generate
    for (gi = 0; gi < NB; gi++) begin : g_flag
      assign pre_ok[gi] = (pc[gi] == '0);
      assign idle[gi]   = !opn[gi] && (rc[gi] == '0);
    end
  endgenerate

  assign pre_all_ok = &pre_ok;
  assign viol       = viol_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NB; i++) begin
        pc[i] <= '0;
        rc[i] <= '0;
      end
      opn    <= '0;
      viol_q <= 1'b0;
    end else begin
      for (int i = 0; i < NB; i++) begin
        logic [CW-1:0] pd, rd;
        logic          hit;
        hit = (cmd_bank == BW'(i));
        pd  = (pc[i] == '0) ? '0 : pc[i] - CW'(1);
        rd  = (rc[i] == '0) ? '0 : rc[i] - CW'(1);
        if ((is_rd || is_wr) && hit) begin
          pc[i]  <= (g_ld > pd) ? g_ld : pd;
          opn[i] <= 1'b1;
        end else begin
          pc[i] <= pd;
        end
        if (is_pra) begin
          rc[i]  <= CW'(cfg_trp);
          opn[i] <= 1'b0;
        end else if (is_pre && hit) begin
          rc[i]  <= CW'(cfg_trp) - CW'(1);
          opn[i] <= 1'b0;
        end else begin
          rc[i] <= rd;
        end
      end
      viol_q <= (is_pre && !pre_ok[cmd_bank]) || (is_pra && !pre_all_ok);
    end
  end
endmodule

// File: rtl/prech_guard_chk.sv
module prech_guard_chk #(
  parameter int NB = 8,
  parameter int BW = $clog2(NB)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic [2:0]    cmd_op,
  input logic [BW-1:0] cmd_bank,
  input logic [NB-1:0] pre_ok,
  input logic [NB-1:0] idle,
  input logic          pre_all_ok,
  input logic          viol
);
  wire rdwr = cmd_valid && (cmd_op >= 3'd1) && (cmd_op <= 3'd4);

  // R10
  viol_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol |-> $past(cmd_valid && ((cmd_op == 3'd5 && !pre_ok[cmd_bank]) ||
                                 (cmd_op == 3'd6 && !pre_all_ok))));

  // R2
  rdwr_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdwr |=> !pre_ok[$past(cmd_bank)]);

  // R8
  pra_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd6) |=> (idle == '0));

  // R6
  ok_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rdwr |=> (($past(pre_ok) & ~pre_ok) == '0));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> (($past(idle) & ~idle) == '0));
endmodule

bind prech_guard prech_guard_chk #(.NB(NB), .BW(BW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .cmd_bank(cmd_bank), .pre_ok(pre_ok), .idle(idle),
  .pre_all_ok(pre_all_ok), .viol(viol)
);

// File: tb/test_prech_guard.sv
module test_prech_guard;
  logic       clk = 0, rst_n = 0, cmd_valid = 0, cfg_bl8 = 1;
  logic [2:0] cmd_op = 0, cmd_bank = 0;
  logic [3:0] cfg_al = 2, cfg_wl = 3;
  logic [5:0] cfg_trtp_ns = 8, cfg_tck_ns = 3;
  logic [4:0] cfg_twr = 5, cfg_trp = 4;
  logic [7:0] pre_ok, idle;
  logic       pre_all_ok, viol;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  prech_guard i_prech_guard (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_bank(cmd_bank), .cfg_al(cfg_al), .cfg_wl(cfg_wl), .cfg_bl8(cfg_bl8),
    .cfg_trtp_ns(cfg_trtp_ns), .cfg_tck_ns(cfg_tck_ns), .cfg_twr(cfg_twr),
    .cfg_trp(cfg_trp), .pre_ok(pre_ok), .idle(idle),
    .pre_all_ok(pre_all_ok), .viol(viol)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wcyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic issue(logic [2:0] op, logic [2:0] b);
    cmd_valid = 1; cmd_op = op; cmd_bank = b;
    @(negedge clk);
    cmd_valid = 0; cmd_op = 0;
  endtask

  task automatic close_bank(logic [2:0] b);
    issue(3'd5, b);
    wcyc(4);
  endtask

  task automatic t_reset;
    check("R1 pre_ok", pre_ok, 8'hff);
    check("R1 idle", idle, 8'hff);
    check("R1 pre_all_ok", pre_all_ok, 1);
    check("R1 viol", viol, 0);
  endtask

  task automatic t_read;
    issue(3'd1, 2);
    check("R11 idle bank2", idle[2], 0);
    check("R11 idle bank3", idle[3], 1);
    check("R11 pre_ok bank3", pre_ok[3], 1);
    wcyc(5); check("R2 rd gap early", pre_ok[2], 0);
    wcyc(1); check("R2 rd gap done", pre_ok[2], 1);
    issue(3'd5, 2);
    check("R10 legal pre", viol, 0);
    check("R7 idle start", idle[2], 0);
    wcyc(2); check("R7 trp early", idle[2], 0);
    wcyc(1); check("R7 trp done", idle[2], 1);
  endtask

  task automatic t_clamp;
    cfg_trtp_ns = 2; cfg_al = 0;
    issue(3'd2, 1);
    wcyc(2); check("R3 clamp early", pre_ok[1], 0);
    wcyc(1); check("R3 clamp done", pre_ok[1], 1);
    close_bank(1);
    cfg_trtp_ns = 8; cfg_al = 2;
  endtask

  task automatic t_write;
    issue(3'd3, 5);
    wcyc(10); check("R4 wr gap early", pre_ok[5], 0);
    wcyc(1);  check("R4 wr gap done", pre_ok[5], 1);
    close_bank(5);
  endtask

  task automatic t_bl4;
    cfg_bl8 = 0;
    issue(3'd4, 6);
    wcyc(8); check("R5 bl4 early", pre_ok[6], 0);
    wcyc(1); check("R5 bl4 done", pre_ok[6], 1);
    close_bank(6);
    cfg_bl8 = 1;
  endtask

  task automatic t_merge;
    cmd_valid = 1; cmd_op = 3'd3; cmd_bank = 0;
    @(negedge clk);
    issue(3'd1, 0);
    wcyc(9); check("R6 no shorten", pre_ok[0], 0);
    wcyc(1); check("R6 long gap done", pre_ok[0], 1);
    wcyc(5); check("R6 saturate", pre_ok[0], 1);
    close_bank(0);
  endtask

  task automatic t_prea;
    issue(3'd1, 4);
    check("R8 all blocked", pre_all_ok, 0);
    wcyc(5); check("R8 all still blocked", pre_all_ok, 0);
    wcyc(1); check("R8 all ready", pre_all_ok, 1);
    issue(3'd6, 0);
    check("R8 legal prea", viol, 0);
    check("R8 idle cleared", idle, 8'h00);
    wcyc(3); check("R8 trpall early", idle, 8'h00);
    wcyc(1); check("R8 trpall done", idle, 8'hff);
  endtask

  task automatic t_restart;
    issue(3'd6, 0);
    wcyc(1);
    issue(3'd5, 1);
    wcyc(2); check("R9 others done", idle, 8'hfd);
    wcyc(1); check("R9 restarted bank", idle, 8'hff);
  endtask

  task automatic t_viol;
    issue(3'd1, 3);
    issue(3'd5, 3);
    check("R10 early pre", viol, 1);
    wcyc(1); check("R10 one pulse", viol, 0);
    wcyc(1); check("R10 recorded", idle[3], 0);
    wcyc(1); check("R10 recorded idle", idle[3], 1);
    wcyc(10);
    issue(3'd3, 7);
    issue(3'd6, 0);
    check("R10 early prea", viol, 1);
    wcyc(20);
    check("R10 settled", idle, 8'hff);
  endtask

  initial begin
    wcyc(3);
    rst_n = 1;
    wcyc(1);
    t_reset;
    t_read;
    t_clamp;
    t_write;
    t_bl4;
    t_merge;
    t_prea;
    t_restart;
    t_viol;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule